// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Emulator

This block behaves like a 64-word by 16-bit serial EEPROM on a three-wire select/clock/data bus. A fast system clock oversamples the chip-select, serial-clock and serial-data pins. A command starts with a start bit. Two opcode bits and six address bits follow, and for write-type commands sixteen data bits come after those. The words are held in an internal register file.

Reads stream words out on the serial output: a single zero bit comes first, and then as many consecutive words as the host keeps clocking. Program operations (single-word write and erase, whole-array write and erase) are guarded by a write-enable latch that is clear after reset. Each program operation occupies a busy period whose length is set by a parameter. A host checks completion by dropping chip select and raising it again: the output then shows 0 while busy and 1 once ready.

The command engine has six states. IDLE waits for a start bit, or shows status. OPC collects the opcode and ADDR collects the address. DATA collects the write data, READ streams output bits, and DONE ignores all bits until chip select drops. Transitions:
- IDLE to OPC when a start bit arrives while not busy.
- OPC to ADDR after two bits.
- ADDR to READ, to DATA or to DONE at the last address bit, depending on the decode.
- DATA to DONE at the last data bit.
- Any state to IDLE when chip select is low.

Top module: `mw_eeprom_emu`

## Requirements
- R1: With chip select high, rising serial-clock edges with data low are ignored until the first edge that samples data high. That edge is the start bit. Before it the output stays undriven (sdo_oe=0).
- R2: The opcode is the two bits after the start bit, MSB first, and selects 10=read, 01=write or 11=erase. Opcode 00 is decoded by the top two address bits: 11=enable, 00=disable, 10=erase all, 01=write all. The other four address bits are ignored.
- R3: For a read, the edge carrying the last address bit drives a 0 with sdo_oe=1. Each following rising edge then drives one bit of the addressed word, MSB first.
- R4: While chip select stays high after the sixteenth bit, the address increments and the next word follows with no zero prefix. The address wraps from 63 to 0.
- R5: After reset, programming is disabled, and write, erase, erase-all and write-all change nothing. Enable turns programming on and disable turns it off again. Read works in both states.
- R6: Write stores the 16 data bits, MSB first, at the given address.
- R7: After reset every word is 16'hFFFF. Erase sets the addressed word to 16'hFFFF, and erase-all sets every word to 16'hFFFF.
- R8: Write-all stores the given data in every word.
- R9: A program operation starts at the last required bit and stays busy for T_WORD cycles (write and erase), T_ERAL cycles (erase-all) or T_WRAL cycles (write-all), whether or not chip select drops. After chip select goes low and then high in IDLE, the output drives 0 while busy and 1 when ready.
- R10: Chip select low returns the engine to IDLE, stops the output driver and abandons an unfinished command.
- R11: A start bit that arrives while a program operation is busy is ignored, together with the command that follows it.
- R12: After the last required bit of a command, further clock edges and data are ignored until chip select goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data or ready/busy status to the host |
| sdo_oe | output | 1 | High while sdo is driven |

## Verification
The hardest situation to reach is the status poll during a busy period. The busy period begins on the last data edge, and the host then has to drop and raise chip select before the period ends. The bench sets the program lengths to a few hundred system clocks and toggles chip select right after the final data bit. It also shifts in a complete disable command during that period, then shows the command was ignored because a later write still takes effect. Write-all is given a longer period than single-word writes, so a poll made after a single-word period has passed can show that the longer count is still running.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_DATA,
        S_READ,
        S_DONE
    } mw_state_e;

    typedef enum logic [1:0] {
        PK_WORD_ERASE,
        PK_WORD_WRITE,
        PK_ALL_ERASE,
        PK_ALL_WRITE
    } prog_kind_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_DIS   = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_EN    = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    output logic cs_s,
    output logic sdi_s,
    output logic sclk_rise
);
    logic [2:0] stage_q [STAGES];
    logic       sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            sclk_d <= 1'b0;
        end else begin
            stage_q[0] <= {cs, sclk, sdi};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            sclk_d <= stage_q[STAGES-1][1];
        end
    end

    assign cs_s      = stage_q[STAGES-1][2];
    assign sdi_s     = stage_q[STAGES-1][0];
    assign sclk_rise = stage_q[STAGES-1][1] & ~sclk_d;

    // R1: a serial clock rise is reported as a single-cycle event
    p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer import mw_eeprom_pkg::*; #(
    parameter int T_WORD = 200,
    parameter int T_ERAL = 300,
    parameter int T_WRAL = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  prog_kind_e kind,
    output logic       busy
);
    localparam int LMAX12 = (T_WORD > T_ERAL) ? T_WORD : T_ERAL;
    localparam int LMAX   = (LMAX12 > T_WRAL) ? LMAX12 : T_WRAL;
    localparam int CNT_W  = $clog2(LMAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;

    always_comb begin
        unique case (kind)
            PK_WORD_ERASE,
            PK_WORD_WRITE: len = CNT_W'(T_WORD);
            PK_ALL_ERASE:  len = CNT_W'(T_ERAL);
            PK_ALL_WRITE:  len = CNT_W'(T_WRAL);
            default:       len = CNT_W'(T_WORD);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (go)           cnt_q <= len;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R9: a started program operation is busy in the following cycle
    p_busy_after_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R9: the busy count only runs down while no new start arrives
    p_busy_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !go) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store import mw_eeprom_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  prog_kind_e        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];
    logic              all_sel;
    logic              erase_sel;

    assign all_sel   = (kind == PK_ALL_ERASE) || (kind == PK_ALL_WRITE);
    assign erase_sel = (kind == PK_ALL_ERASE) || (kind == PK_WORD_ERASE);

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (we && (all_sel || addr == ADDR_W'(i))) begin
                word_q <= erase_sel ? '1 : wdata;
            end
        end
        assign words[i] = word_q;
    end

    assign rdata = words[raddr];

    // R7: a single-word erase leaves the addressed word all ones
    p_word_erased_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == PK_WORD_ERASE) |=> (words[$past(addr)] == '1));

    // R8: a write-all lands its data in word zero as in every other word
    p_all_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == PK_ALL_WRITE) |=> (words[0] == $past(wdata)));

endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm import mw_eeprom_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    input  logic              busy,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              prog_go,
    output prog_kind_e        prog_kind,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CNT_W = $clog2(DATA_W + ADDR_W);
    localparam int IDX_W = $clog2(DATA_W);

    mw_state_e         state, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_sr, addr_q, rd_addr;
    logic [DATA_W-1:0] data_sr, data_q;
    logic              rd_bit, wr_en, arm;
    logic              edge_ok, last_addr, last_data, go_d, start_ok;
    logic [ADDR_W-1:0] addr_full;
    logic [DATA_W-1:0] data_full;
    logic [1:0]        top2;
    logic [IDX_W-1:0]  bit_idx;
    prog_kind_e        kind_d;

    assign edge_ok   = cs_s & sclk_rise;
    assign addr_full = {addr_sr[ADDR_W-2:0], sdi_s};
    assign data_full = {data_sr[DATA_W-2:0], sdi_s};
    assign top2      = addr_full[ADDR_W-1 -: 2];
    assign last_addr = edge_ok && state == S_ADDR && cnt_q == CNT_W'(ADDR_W - 1);
    assign last_data = edge_ok && state == S_DATA && cnt_q == CNT_W'(DATA_W - 1);
    assign start_ok  = edge_ok && state == S_IDLE && sdi_s && !busy;
    assign bit_idx   = IDX_W'(DATA_W - 1) - IDX_W'(cnt_q);

    // Next-state decode
    always_comb begin
        state_d = state;
        if (!cs_s) begin
            state_d = S_IDLE;
        end else if (sclk_rise) begin
            unique case (state)
                S_IDLE: if (sdi_s && !busy) state_d = S_OPC;
                S_OPC:  if (cnt_q == CNT_W'(1)) state_d = S_ADDR;
                S_ADDR: if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                    unique case (op_q)
                        OPC_READ:  state_d = S_READ;
                        OPC_WRITE: state_d = S_DATA;
                        OPC_ERASE: state_d = S_DONE;
                        default:   state_d = (top2 == EXT_WRALL) ? S_DATA : S_DONE;
                    endcase
                end
                S_DATA: if (cnt_q == CNT_W'(DATA_W - 1)) state_d = S_DONE;
                S_READ: state_d = S_READ;
                S_DONE: state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Program request decode
    always_comb begin
        go_d   = 1'b0;
        kind_d = PK_WORD_ERASE;
        if (last_addr) begin
            if (op_q == OPC_ERASE) begin
                go_d   = wr_en;
                kind_d = PK_WORD_ERASE;
            end else if (op_q == OPC_EXT && top2 == EXT_ERALL) begin
                go_d   = wr_en;
                kind_d = PK_ALL_ERASE;
            end
        end else if (last_data) begin
            go_d   = wr_en;
            kind_d = (op_q == OPC_WRITE) ? PK_WORD_WRITE : PK_ALL_WRITE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            op_q      <= '0;
            addr_sr   <= '0;
            addr_q    <= '0;
            data_sr   <= '0;
            data_q    <= '0;
            rd_addr   <= '0;
            rd_bit    <= 1'b0;
            wr_en     <= 1'b0;
            arm       <= 1'b0;
            prog_go   <= 1'b0;
            prog_kind <= PK_WORD_ERASE;
        end else begin
            prog_go   <= go_d;
            prog_kind <= kind_d;
            if (state_d != state) begin
                cnt_q <= '0;
            end else if (edge_ok) begin
                cnt_q <= (state == S_READ && cnt_q == CNT_W'(DATA_W - 1)) ? '0 : cnt_q + 1'b1;
            end
            if (edge_ok && state == S_OPC)  op_q    <= {op_q[0], sdi_s};
            if (edge_ok && state == S_ADDR) addr_sr <= addr_full;
            if (edge_ok && state == S_DATA) data_sr <= data_full;
            if (last_addr) addr_q <= addr_full;
            if (last_data) data_q <= data_full;
            if (last_addr && op_q == OPC_EXT) begin
                if (top2 == EXT_EN)  wr_en <= 1'b1;
                if (top2 == EXT_DIS) wr_en <= 1'b0;
            end
            if (last_addr && op_q == OPC_READ) begin
                rd_bit  <= 1'b0;
                rd_addr <= addr_full;
            end else if (edge_ok && state == S_READ) begin
                rd_bit <= rdata[bit_idx];
                if (cnt_q == CNT_W'(DATA_W - 1)) rd_addr <= rd_addr + 1'b1;
            end
            if (go_d)          arm <= 1'b1;
            else if (start_ok) arm <= 1'b0;
        end
    end

    assign raddr     = rd_addr;
    assign prog_addr = addr_q;
    assign prog_data = data_q;

    // Output decode
    always_comb begin
        sdo_oe = cs_s && (state == S_READ || (state == S_IDLE && arm));
        sdo    = (state == S_READ) ? rd_bit : !busy;
    end

    logic in_read;
    assign in_read = (state == S_READ);

    // R3: the first bit after entering the read state is the zero prefix
    p_dummy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_read) |-> !sdo);

    // R5: a program operation is only requested while programming is enabled
    p_go_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wr_en);

    // R11: no program operation is requested during a busy period
    p_go_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> !busy);

    // R10: a low chip select leaves the engine idle one cycle later
    p_cs_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (state == S_IDLE));

endmodule

// File: rtl/mw_eeprom_emu.sv
module mw_eeprom_emu import mw_eeprom_pkg::*; #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int T_WORD      = 200,
    parameter int T_ERAL      = 300,
    parameter int T_WRAL      = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic              cs_s, sdi_s, sclk_rise, busy, prog_go;
    prog_kind_e        prog_kind;
    logic [ADDR_W-1:0] raddr, prog_addr;
    logic [DATA_W-1:0] rdata, prog_data;

    mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .cs_s(cs_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise)
    );

    mw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdi_s(sdi_s),
        .sclk_rise(sclk_rise), .busy(busy), .rdata(rdata), .raddr(raddr),
        .prog_go(prog_go), .prog_kind(prog_kind), .prog_addr(prog_addr),
        .prog_data(prog_data), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(prog_go), .kind(prog_kind),
        .addr(prog_addr), .wdata(prog_data), .raddr(raddr), .rdata(rdata)
    );

    mw_prog_timer #(.T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(prog_go), .kind(prog_kind), .busy(busy)
    );

endmodule

// File: tb/mw_eeprom_emu_tb.sv
module mw_eeprom_emu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int T_WORD     = 200;
    localparam int T_ERAL     = 300;
    localparam int T_WRAL     = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;
    int   n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_emu #(.T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic o, output logic oe);
        sdi = b;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
        o  = sdo;
        oe = sdo_oe;
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic o, oe;
        for (int i = n - 1; i >= 0; i--) bit_io(v[i], o, oe);
    endtask

    task automatic cs_up();
        cs = 1'b1;
        wait_clk(6);
    endtask

    task automatic cs_dn();
        cs = 1'b0;
        sdi = 1'b0;
        wait_clk(6);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [5:0] a);
        send_bits({23'd0, 1'b1, op, a}, 9);
    endtask

    task automatic ext(input logic [5:0] a);
        cs_up(); cmd(2'b00, a); cs_dn();
    endtask

    task automatic prog_word(input logic [5:0] a, input logic [15:0] d);
        cs_up(); cmd(2'b01, a); send_bits({16'd0, d}, 16); cs_dn();
        wait_clk(T_WORD + 20);
    endtask

    task automatic read_stream(input logic [5:0] a, input int pre,
                               output logic [15:0] w0, output logic [15:0] w1,
                               output logic dz, output logic dz_oe);
        logic o, oe;
        cs_up();
        send_bits(32'd0, pre);
        send_bits({23'd0, 1'b1, 2'b10, a[5:1]}, 8);
        bit_io(a[0], dz, dz_oe);
        for (int i = 15; i >= 0; i--) begin bit_io(1'b0, o, oe); w0[i] = o; end
        for (int i = 15; i >= 0; i--) begin bit_io(1'b0, o, oe); w1[i] = o; end
        cs_dn();
    endtask

    task automatic read_word(input logic [5:0] a, output logic [15:0] w);
        logic [15:0] w1;
        logic dz, dzo;
        read_stream(a, 0, w, w1, dz, dzo);
    endtask

    task automatic t_reset();
        logic [15:0] w0, w1;
        logic dz, dzo, o, oe;
        check("R1 reset oe", {31'd0, sdo_oe}, 32'd0);
        cs_up();
        for (int i = 0; i < 4; i++) begin
            bit_io(1'b0, o, oe);
            check("R1 idle oe before start", {31'd0, oe}, 32'd0);
        end
        cs_dn();
        read_stream(6'd5, 5, w0, w1, dz, dzo);
        check("R3 dummy value", {31'd0, dz}, 32'd0);
        check("R3 dummy driven", {31'd0, dzo}, 32'd1);
        check("R7 reset word ones", {16'd0, w0}, 32'h0000FFFF);
    endtask

    task automatic t_protect();
        logic [15:0] w;
        prog_word(6'd3, 16'h1234);
        read_word(6'd3, w);
        check("R5 write while disabled", {16'd0, w}, 32'h0000FFFF);
    endtask

    task automatic t_write();
        logic [15:0] w;
        logic o, oe;
        ext(6'b110000);
        cs_up(); cmd(2'b01, 6'd3); send_bits(32'h0000A5C3, 16); cs_dn();
        cs_up();
        check("R9 status driven", {31'd0, sdo_oe}, 32'd1);
        check("R9 busy reads 0", {31'd0, sdo}, 32'd0);
        wait_clk(T_WORD + 20);
        check("R9 ready reads 1", {31'd0, sdo}, 32'd1);
        cs_dn();
        read_word(6'd3, w);
        check("R6 R2 word written", {16'd0, w}, 32'h0000A5C3);
    endtask

    task automatic t_seq();
        logic [15:0] w0, w1;
        logic dz, dzo;
        prog_word(6'd63, 16'h1111);
        prog_word(6'd0, 16'h2222);
        read_stream(6'd63, 0, w0, w1, dz, dzo);
        check("R4 first word", {16'd0, w0}, 32'h00001111);
        check("R4 wrapped word", {16'd0, w1}, 32'h00002222);
        read_stream(6'd2, 0, w0, w1, dz, dzo);
        check("R4 increment", {16'd0, w1}, 32'h0000A5C3);
    endtask

    task automatic t_erase();
        logic [15:0] w;
        cs_up(); cmd(2'b11, 6'd3); cs_dn();
        wait_clk(T_WORD + 20);
        read_word(6'd3, w);
        check("R7 word erase", {16'd0, w}, 32'h0000FFFF);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] w;
        cs_up(); cmd(2'b01, 6'd10); send_bits(32'h00000F0F, 16); cs_dn();
        cs_up(); cmd(2'b00, 6'b000000); cs_dn();
        wait_clk(T_WORD);
        prog_word(6'd11, 16'h7777);
        read_word(6'd11, w);
        check("R11 disable during busy ignored", {16'd0, w}, 32'h00007777);
        read_word(6'd10, w);
        check("R6 busy write kept", {16'd0, w}, 32'h00000F0F);
    endtask

    task automatic t_trailing();
        logic [15:0] w;
        cs_up();
        cmd(2'b00, 6'b110000);
        cmd(2'b01, 6'd12);
        send_bits(32'h00004321, 16);
        cs_dn();
        wait_clk(T_WORD + 20);
        read_word(6'd12, w);
        check("R12 trailing bits ignored", {16'd0, w}, 32'h0000FFFF);
    endtask

    task automatic t_disable();
        logic [15:0] w;
        ext(6'b000000);
        cs_up(); cmd(2'b11, 6'd11); cs_dn();
        wait_clk(T_WORD + 20);
        read_word(6'd11, w);
        check("R5 erase after disable", {16'd0, w}, 32'h00007777);
    endtask

    task automatic t_wral();
        logic [15:0] w;
        ext(6'b110000);
        cs_up(); cmd(2'b00, 6'b010000); send_bits(32'h00003C3C, 16); cs_dn();
        cs_up();
        check("R9 write-all busy", {31'd0, sdo}, 32'd0);
        wait_clk(T_WORD + 40);
        check("R9 write-all longer than word", {31'd0, sdo}, 32'd0);
        wait_clk(T_WRAL);
        check("R9 write-all ready", {31'd0, sdo}, 32'd1);
        cs_dn();
        read_word(6'd0, w);
        check("R8 write-all word 0", {16'd0, w}, 32'h00003C3C);
        read_word(6'd40, w);
        check("R8 write-all word 40", {16'd0, w}, 32'h00003C3C);
    endtask

    task automatic t_eral();
        logic [15:0] w;
        cs_up(); cmd(2'b00, 6'b101010); cs_dn();
        cs_up();
        check("R9 erase-all busy", {31'd0, sdo}, 32'd0);
        wait_clk(T_ERAL + 20);
        check("R9 erase-all ready", {31'd0, sdo}, 32'd1);
        cs_dn();
        read_word(6'd7, w);
        check("R7 erase-all word 7", {16'd0, w}, 32'h0000FFFF);
    endtask

    task automatic t_abort();
        logic [15:0] w;
        cs_up(); cmd(2'b01, 6'd20); send_bits(32'h000000AB, 8); cs_dn();
        wait_clk(T_WORD + 20);
        read_word(6'd20, w);
        check("R10 partial write abandoned", {16'd0, w}, 32'h0000FFFF);
        cs_up(); cmd(2'b10, 6'd20); send_bits(32'd0, 5);
        check("R10 read driving", {31'd0, sdo_oe}, 32'd1);
        cs_dn();
        check("R10 cs low stops driver", {31'd0, sdo_oe}, 32'd0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_protect();
        t_write();
        t_seq();
        t_erase();
        t_busy_ignore();
        t_trailing();
        t_disable();
        t_wral();
        t_eral();
        t_abort();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule